// File: doc/BRIEF.md
# Motor Fault Supervisor

This block decides whether a three-phase brushless fan drive may switch. It watches the three hall sensor levels, a speed-command-zero flag, a flag telling whether the speed command is above its minimum, an undervoltage flag, a thermal flag, a one-cycle strobe at every carrier period and a one-cycle millisecond tick. It produces one registered drive-enable output and an active-low fault flag that is asserted exactly while the drive is held off.

It handles three kinds of fault. The first is a stalled rotor: the block times the gap between hall edges, forces a timed off period and then retries on its own. The second is a broken hall sensor: an impossible code blocks the drive at once, and a run of bad revolutions latches the drive off until the speed command is taken to zero. The third is a supply sag: after the supply recovers, the drive restarts only after a fixed count of carrier periods and in step with a carrier boundary. All time limits are parameters, so a test bench can shorten them.

Top module: `motor_fault_supervisor`

## Requirements
- R1: When the speed command is above its minimum and LOCK_DET_MS millisecond ticks pass with no change on any hall input, a lock is declared and drv_en goes low within four cycles of that tick. Ticks that arrive while the command is not above its minimum never declare a lock.
- R2: A declared lock holds drv_en low for LOCK_OFF_MS ticks. After that the drive is re-enabled with no outside action.
- R3: Hall input changes during the lock-off period neither shorten it nor restart it.
- R4: Asserting spd_zero_i ends the lock-off period at once, so drv_en returns high two cycles later if no other fault is present.
- R5: A hall code of 3'b000 or 3'b111 (packed as {U,V,W}) forces drv_en low on the clock edge after it is sampled, and only for as long as the code persists.
- R6: A revolution ends on each falling edge of hall U. When BAD_REVS revolutions in a row each contain an illegal code, drv_en latches low. A revolution with no illegal code restarts the run. Only spd_zero_i releases the latch.
- R7: While ot_i is high, drv_en is low.
- R8: While uv_i is high, drv_en is low, and the same holds after reset. Once uv_i is low, drv_en stays low until UV_WAIT carrier strobes have been counted. Strobes that arrive while uv_i is high do not count. drv_en rises on the second clock edge after the final strobe is sampled.
- R9: fault_n_o is low exactly when drv_en_o is low. Both outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hall_i | input | 3 | Hall levels {U,V,W}, already synchronised |
| spd_zero_i | input | 1 | Speed command is at zero |
| spd_above_min_i | input | 1 | Speed command is above its minimum |
| uv_i | input | 1 | Undervoltage flag |
| ot_i | input | 1 | Thermal shutdown flag |
| carrier_stb_i | input | 1 | One-cycle pulse at each carrier period |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| drv_en_o | output | 1 | Drive enable |
| fault_n_o | output | 1 | Fault flag, low while the drive is held off |

## Verification
The lock timer is tried three ways: with a stationary rotor (the stall is declared on exactly the limit tick and not on the tick before), with the speed command below its minimum (no stall ever), and with a random forward and reverse hall walk that never gaps long enough (no false stall). The hall checker is fed single impossible codes, which show the drive blocking only while the code lasts, and runs of revolutions with one bad code each. A clean revolution inserted in a run tells a consecutive count apart from a cumulative one. The supply recovery is timed strobe by strobe, with extra strobes given during the sag, which shows whether strobes that arrive before release are wrongly counted.

// File: rtl/msup_pkg.sv
package msup_pkg;
  typedef enum logic {LK_WATCH = 1'b0, LK_OFF = 1'b1} lock_state_e;

  function automatic logic hall_illegal(input logic [2:0] h);
    return (h == 3'b000) || (h == 3'b111);
  endfunction
endpackage

// File: rtl/msup_lock_timer.sv
module msup_lock_timer
  import msup_pkg::*;
#(
  parameter int LOCK_DET_MS = 4000,
  parameter int LOCK_OFF_MS = 20000
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [2:0] hall_i,
  input  logic       spd_zero_i,
  input  logic       spd_above_min_i,
  input  logic       tick_ms_i,
  output logic       lock_off_o
);
  localparam int MAXT = (LOCK_DET_MS > LOCK_OFF_MS) ? LOCK_DET_MS : LOCK_OFF_MS;
  localparam int CW   = $clog2(MAXT + 1);

  lock_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    hall_q;
  logic          edge_seen;

  assign edge_seen = (hall_i != hall_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= LK_WATCH;
      cnt_q   <= '0;
      hall_q  <= hall_i;
    end else begin
      hall_q <= hall_i;
      if (spd_zero_i) begin
        state_q <= LK_WATCH;
        cnt_q   <= '0;
      end else if (state_q == LK_WATCH) begin
        if (!spd_above_min_i || edge_seen) begin
          cnt_q <= '0;
        end else if (tick_ms_i) begin
          if (cnt_q == CW'(LOCK_DET_MS - 1)) begin
            state_q <= LK_OFF;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else if (tick_ms_i) begin
        if (cnt_q == CW'(LOCK_OFF_MS - 1)) begin
          state_q <= LK_WATCH;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign lock_off_o = (state_q == LK_OFF);
endmodule

// File: rtl/msup_hall_check.sv
module msup_hall_check
  import msup_pkg::*;
#(
  parameter int BAD_REVS = 4
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [2:0] hall_i,
  input  logic       spd_zero_i,
  output logic       bad_now_o,
  output logic       latched_o
);
  localparam int RW = $clog2(BAD_REVS + 1);

  logic          u_q;
  logic          seen_q;
  logic [RW-1:0] revs_q;
  logic          latch_q;
  logic          u_fall;
  logic          rev_bad;

  assign bad_now_o = hall_illegal(hall_i);
  assign u_fall    = u_q && !hall_i[2];
  assign rev_bad   = seen_q || bad_now_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      u_q     <= hall_i[2];
      seen_q  <= 1'b0;
      revs_q  <= '0;
      latch_q <= 1'b0;
    end else begin
      u_q <= hall_i[2];
      if (spd_zero_i) begin
        seen_q  <= 1'b0;
        revs_q  <= '0;
        latch_q <= 1'b0;
      end else if (u_fall) begin
        seen_q <= 1'b0;
        if (rev_bad) begin
          if (revs_q >= RW'(BAD_REVS - 1)) begin
            latch_q <= 1'b1;
            revs_q  <= RW'(BAD_REVS);
          end else begin
            revs_q <= revs_q + 1'b1;
          end
        end else begin
          revs_q <= '0;
        end
      end else if (bad_now_o) begin
        seen_q <= 1'b1;
      end
    end
  end

  assign latched_o = latch_q;
endmodule

// File: rtl/msup_uv_recover.sv
module msup_uv_recover #(
  parameter int UV_WAIT = 32
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic uv_i,
  input  logic carrier_stb_i,
  output logic blocked_o
);
  localparam int WW = $clog2(UV_WAIT + 1);

  logic          blk_q;
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || uv_i) begin
      blk_q <= 1'b1;
      cnt_q <= '0;
    end else if (blk_q && carrier_stb_i) begin
      if (cnt_q == WW'(UV_WAIT - 1)) begin
        blk_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign blocked_o = blk_q;
endmodule

// File: rtl/motor_fault_supervisor.sv
module motor_fault_supervisor #(
  parameter int LOCK_DET_MS = 4000,
  parameter int LOCK_OFF_MS = 20000,
  parameter int BAD_REVS    = 4,
  parameter int UV_WAIT     = 32
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [2:0] hall_i,
  input  logic       spd_zero_i,
  input  logic       spd_above_min_i,
  input  logic       uv_i,
  input  logic       ot_i,
  input  logic       carrier_stb_i,
  input  logic       tick_ms_i,
  output logic       drv_en_o,
  output logic       fault_n_o
);
  logic lock_off;
  logic hall_bad;
  logic hall_latched;
  logic uv_blocked;
  logic en_d;

  msup_lock_timer #(
    .LOCK_DET_MS(LOCK_DET_MS),
    .LOCK_OFF_MS(LOCK_OFF_MS)
  ) u_lock (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .hall_i         (hall_i),
    .spd_zero_i     (spd_zero_i),
    .spd_above_min_i(spd_above_min_i),
    .tick_ms_i      (tick_ms_i),
    .lock_off_o     (lock_off)
  );

  msup_hall_check #(
    .BAD_REVS(BAD_REVS)
  ) u_hall (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .hall_i    (hall_i),
    .spd_zero_i(spd_zero_i),
    .bad_now_o (hall_bad),
    .latched_o (hall_latched)
  );

  msup_uv_recover #(
    .UV_WAIT(UV_WAIT)
  ) u_uv (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .uv_i         (uv_i),
    .carrier_stb_i(carrier_stb_i),
    .blocked_o    (uv_blocked)
  );

  assign en_d = !(lock_off || hall_bad || hall_latched || uv_blocked || uv_i || ot_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      drv_en_o  <= 1'b0;
      fault_n_o <= 1'b0;
    end else begin
      drv_en_o  <= en_d;
      fault_n_o <= en_d;
    end
  end
endmodule

// File: rtl/msup_checker.sv
module msup_checker (
  input logic       clk_i,
  input logic       rst_i,
  input logic [2:0] hall_i,
  input logic       uv_i,
  input logic       ot_i,
  input logic       drv_en_o
);
  a_r5_illegal_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
    ((hall_i == 3'b000) || (hall_i == 3'b111)) |=> !drv_en_o);

  a_r7_thermal_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
    ot_i |=> !drv_en_o);

  a_r8_uv_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
    uv_i |=> !drv_en_o);

  a_r8_no_rise_from_uv: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(drv_en_o) |-> !$past(uv_i));
endmodule

bind motor_fault_supervisor msup_checker u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .hall_i  (hall_i),
  .uv_i    (uv_i),
  .ot_i    (ot_i),
  .drv_en_o(drv_en_o)
);

// File: tb/motor_fault_supervisor_tb.sv
`timescale 1ns/1ps
module motor_fault_supervisor_tb;
  localparam int LD = 8;
  localparam int LO = 12;
  localparam int BR = 4;
  localparam int UW = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hall = 3'b101;
  logic       spd_zero = 1'b0;
  logic       above = 1'b0;
  logic       uv = 1'b0;
  logic       ot = 1'b0;
  logic       stb = 1'b0;
  logic       tick = 1'b0;
  logic       drv_en;
  logic       fault_n;

  int checks = 0;
  int fails = 0;
  int idx = 0;
  bit done = 0;

  always #2 clk = ~clk;

  motor_fault_supervisor #(
    .LOCK_DET_MS(LD), .LOCK_OFF_MS(LO), .BAD_REVS(BR), .UV_WAIT(UW)
  ) u_dut (
    .clk_i(clk), .rst_i(rst), .hall_i(hall), .spd_zero_i(spd_zero),
    .spd_above_min_i(above), .uv_i(uv), .ot_i(ot), .carrier_stb_i(stb),
    .tick_ms_i(tick), .drv_en_o(drv_en), .fault_n_o(fault_n)
  );

  function automatic logic [2:0] code(int i);
    case (i)
      0: return 3'b101;
      1: return 3'b100;
      2: return 3'b110;
      3: return 3'b010;
      4: return 3'b011;
      default: return 3'b001;
    endcase
  endfunction

  function automatic logic exp_legal(logic [2:0] h);
    return !(h == 3'b000 || h == 3'b111);
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic tick_pulse();
    tick = 1'b1; cyc(1); tick = 1'b0; cyc(3);
  endtask

  task automatic stb_pulse();
    stb = 1'b1; cyc(1); stb = 1'b0; cyc(3);
  endtask

  task automatic set_hall(logic [2:0] v);
    hall = v; cyc(2);
  endtask

  task automatic advance(bit fwd);
    idx = fwd ? (idx + 1) % 6 : (idx + 5) % 6;
    set_hall(code(idx));
  endtask

  task automatic rev(bit bad);
    for (int i = 0; i < 6; i++) begin
      idx = i;
      set_hall(code(i));
      if (bad && i == 0) set_hall(3'b111);
    end
  endtask

  task automatic uv_release_exact(string req);
    repeat (UW - 1) stb_pulse();
    check(req, drv_en, 1'b0);
    stb = 1'b1; cyc(1); stb = 1'b0;
    check(req, drv_en, 1'b0);
    cyc(1);
    check(req, drv_en, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    cyc(4);
    rst = 1'b0;
    cyc(1);
    // Reset state: supply wait active
    check("R8 reset", drv_en, 1'b0);
    check("R9 reset", fault_n, 1'b0);
    uv_release_exact("R8 after reset");
    check("R9 enabled", fault_n, 1'b1);

    // Stall detection
    above = 1'b1;
    repeat (LD - 1) tick_pulse();
    check("R1 before limit", drv_en, 1'b1);
    tick_pulse();
    check("R1 lock", drv_en, 1'b0);
    check("R9 lock", fault_n, 1'b0);

    // Edges during the off period are ignored
    repeat (LO - 1) begin
      advance(1'b1);
      tick_pulse();
    end
    check("R3 edges ignored", drv_en, 1'b0);
    tick_pulse();
    check("R2 auto retry", drv_en, 1'b1);

    // Below minimum: no lock
    above = 1'b0;
    repeat (LD + 3) tick_pulse();
    check("R1 below min", drv_en, 1'b1);
    above = 1'b1;

    // Zero command cancels off period
    repeat (LD) tick_pulse();
    check("R4 locked", drv_en, 1'b0);
    spd_zero = 1'b1; above = 1'b0;
    cyc(2);
    check("R4 cancel", drv_en, 1'b1);
    spd_zero = 1'b0; above = 1'b1;
    cyc(1);

    // Illegal codes
    hall = 3'b000; cyc(1);
    check("R5 code 000", drv_en, 1'b0);
    set_hall(code(idx));
    check("R5 recover", drv_en, exp_legal(hall));
    hall = 3'b111; cyc(1);
    check("R5 code 111", drv_en, 1'b0);
    set_hall(code(idx));
    check("R5 recover 2", drv_en, 1'b1);

    spd_zero = 1'b1; cyc(1); spd_zero = 1'b0; cyc(1);

    // Consecutive bad revolutions
    repeat (BR - 1) rev(1'b1);
    rev(1'b0);
    repeat (BR - 1) rev(1'b1);
    check("R6 run broken", drv_en, 1'b1);
    rev(1'b1);
    check("R6 latched", drv_en, 1'b0);
    rev(1'b0);
    check("R6 stays latched", drv_en, 1'b0);
    spd_zero = 1'b1; cyc(1); spd_zero = 1'b0; cyc(2);
    check("R6 released", drv_en, 1'b1);

    // Thermal
    ot = 1'b1; cyc(1);
    check("R7 thermal", drv_en, 1'b0);
    ot = 1'b0; cyc(2);
    check("R7 release", drv_en, 1'b1);

    // Supply sag with strobes during the sag
    uv = 1'b1; cyc(1);
    check("R8 sag", drv_en, 1'b0);
    check("R9 sag", fault_n, 1'b0);
    repeat (40) stb_pulse();
    uv = 1'b0; cyc(1);
    uv_release_exact("R8 recovery");

    // Random hall walk with ticks: no false stall
    begin
      int since = 0;
      for (int n = 0; n < 300; n++) begin
        int r = $urandom;
        if ((r % 3 == 0) || since >= 3) begin
          advance(r[4]);
          since = 0;
        end else begin
          since++;
        end
        tick_pulse();
        if (r % 17 == 5) begin
          ot = 1'b1; cyc(1);
          check("R7 random", drv_en, 1'b0);
          ot = 1'b0; cyc(2);
        end
        check("R1 random walk", drv_en, 1'b1);
      end
    end

    finish_run();
  end
endmodule